// File: doc/BRIEF.md
# Game Session Protocol Controller

This block runs the turn-taking side of a two-player tile game played over a text serial link. A line receiver upstream hands it one decoded line at a time, tagged by kind: a "play white" command, a "play black" command, an opponent move, or anything else. The controller records which side the device holds and whose turn it is. When a reply is due, it raises a request to a move engine. It then forwards the engine's move, once, to a line formatter for sending.

On a white assignment the controller asks the engine for an opening move at once. It does not wait for any input. On a black assignment it stays silent until the opponent moves. Every request runs under a deadline counter sized from the clock frequency, so that a reply leaves within one second of the line that caused it. If the engine misses the deadline, the game is abandoned. Any new colour command restarts the session, whatever state it is in.

Moves are carried as a packed code `{column, row, tile}`. The tile sits in bits [1:0] with 0 = straight "+", 1 = curve "/", 2 = curve "\", 3 = unused. The row is in the next `ROW_W` bits and the column is in the top `COL_W` bits. Column 0 and row 0 are the leftmost and topmost empty positions.

Top module: `game_session_ctrl`

## Requirements
- R1: While and right after reset, `game_on`, `eng_req`, `tx_valid`, `timeout` and `proto_err` are all 0.
- R2: A line of kind 1 (play white) gives, on the next cycle, `game_on`=1, `is_white`=1, `eng_req`=1 and `eng_opening`=1, with no move line needed.
- R3: A line of kind 2 (play black) gives, on the next cycle, `game_on`=1 and `is_white`=0, while `eng_req` and `tx_valid` stay 0.
- R4: In a game with no request outstanding, a line of kind 3 (move) raises `eng_req` with `eng_opening`=0 on the next cycle. `eng_req` then stays high until the request is answered or ends.
- R5: `eng_done` counts only while `eng_req` is high. It produces exactly one `tx_valid` pulse on the next cycle, carrying the move, and `eng_req` falls on that same cycle. `eng_done` at any other time is ignored.
- R6: An opening reply is sent with column 0 and row 0. Tile 0 is kept, and any other tile code is sent as 1, so the only openings are "@0+" and "@0/".
- R7: The engine's answer is accepted during the first `CLK_HZ` cycles that `eng_req` is high. If it has not come by then, the next cycle shows a one-cycle `timeout` pulse with `game_on`=0 and `eng_req`=0, and no reply is sent.
- R8: A colour command restarts the game in any state. An outstanding request is dropped, and an `eng_done` in the same cycle as the command sends nothing.
- R9: A move line that arrives while `eng_req` is high gives a one-cycle `proto_err` pulse on the next cycle and starts no new request. If `eng_done` comes in that same cycle, the pending reply is still sent.
- R10: Lines of kind 0, and move lines when no game is running, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_valid | input | 1 | A decoded line is present this cycle |
| line_kind | input | 2 | 0 other, 1 play white, 2 play black, 3 move |
| eng_req | output | 1 | Reply move wanted from the engine |
| eng_opening | output | 1 | The wanted move is the opening move |
| eng_done | input | 1 | Engine move is valid this cycle |
| eng_move | input | COL_W+ROW_W+2 | Engine move code |
| tx_valid | output | 1 | One-cycle strobe to the formatter |
| tx_move | output | COL_W+ROW_W+2 | Move code to send |
| game_on | output | 1 | A game is in progress |
| is_white | output | 1 | Device holds white |
| timeout | output | 1 | Deadline expired, game abandoned |
| proto_err | output | 1 | Move line dropped while a reply was pending |

## Verification
Two events can land on the same edge. One is an incoming line: a move line or a colour command. The other is the engine finishing a pending request. The bench sets up both cases. When a move line and `eng_done` arrive together, the bench expects the pending reply to go out together with a `proto_err` pulse. When a colour command and `eng_done` arrive together, the bench expects nothing to be sent and the new game to begin. A second collision is also checked: the engine's answer on the last allowed cycle against the deadline expiring. The bench runs one case on each side of that boundary.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [1:0] {
    LK_OTHER = 2'd0,
    LK_WHITE = 2'd1,
    LK_BLACK = 2'd2,
    LK_MOVE  = 2'd3
  } line_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_PEND = 2'd2
  } sess_st_e;

  localparam logic [1:0] TILE_STRAIGHT = 2'd0;
  localparam logic [1:0] TILE_SLASH    = 2'd1;
endpackage

// File: rtl/gs_deadline.sv
module gs_deadline #(
  parameter int LIMIT = 50_000_000,
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic last
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear | run;
    cnt_d  = clear ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = run && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/gs_open_fix.sv
module gs_open_fix
  import gs_pkg::*;
#(
  parameter int COL_W = 6,
  parameter int ROW_W = 6,
  localparam int MOVE_W = COL_W + ROW_W + 2
) (
  input  logic              opening,
  input  logic [MOVE_W-1:0] mv_in,
  output logic [MOVE_W-1:0] mv_out
);
  logic [1:0] tile_fix;

  always_comb begin
    tile_fix = (mv_in[1:0] == TILE_STRAIGHT) ? TILE_STRAIGHT : TILE_SLASH;
    if (opening) mv_out = {{(COL_W + ROW_W){1'b0}}, tile_fix};
    else         mv_out = mv_in;
  end
endmodule

// File: rtl/game_session_ctrl.sv
module game_session_ctrl
  import gs_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int COL_W  = 6,
  parameter int ROW_W  = 6,
  localparam int MOVE_W = COL_W + ROW_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_valid,
  input  logic [1:0]        line_kind,
  output logic              eng_req,
  output logic              eng_opening,
  input  logic              eng_done,
  input  logic [MOVE_W-1:0] eng_move,
  output logic              tx_valid,
  output logic [MOVE_W-1:0] tx_move,
  output logic              game_on,
  output logic              is_white,
  output logic              timeout,
  output logic              proto_err
);
  sess_st_e    st_q, st_d;
  logic        white_q, white_d;
  logic        open_q, open_d;
  logic        tx_q, tx_d;
  logic        to_q, to_d;
  logic        err_q, err_d;
  logic [MOVE_W-1:0] txm_q, fixed_mv;
  logic        start, send, last;
  logic        cmd_w, cmd_b, mv_line;
  line_kind_e  kind;

  assign kind    = line_kind_e'(line_kind);
  assign cmd_w   = line_valid && (kind == LK_WHITE);
  assign cmd_b   = line_valid && (kind == LK_BLACK);
  assign mv_line = line_valid && (kind == LK_MOVE);

  gs_deadline #(.LIMIT(CLK_HZ)) u_deadline (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start),
    .run   ((st_q == ST_PEND) && !eng_done),
    .last  (last)
  );

  gs_open_fix #(.COL_W(COL_W), .ROW_W(ROW_W)) u_open_fix (
    .opening (open_q),
    .mv_in   (eng_move),
    .mv_out  (fixed_mv)
  );

  always_comb begin
    st_d    = st_q;
    white_d = white_q;
    open_d  = open_q;
    start   = 1'b0;
    send    = 1'b0;
    to_d    = 1'b0;
    err_d   = 1'b0;
    if (cmd_w) begin
      st_d    = ST_PEND;
      white_d = 1'b1;
      open_d  = 1'b1;
      start   = 1'b1;
    end else if (cmd_b) begin
      st_d    = ST_WAIT;
      white_d = 1'b0;
      open_d  = 1'b0;
    end else begin
      unique case (st_q)
        ST_WAIT: if (mv_line) begin
          st_d   = ST_PEND;
          open_d = 1'b0;
          start  = 1'b1;
        end
        ST_PEND: begin
          if (eng_done) begin
            st_d = ST_WAIT;
            send = 1'b1;
          end else if (last) begin
            st_d = ST_IDLE;
            to_d = 1'b1;
          end
          err_d = mv_line;
        end
        default: ;
      endcase
    end
    tx_d = send;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      white_q <= 1'b0;
      open_q  <= 1'b0;
      tx_q    <= 1'b0;
      to_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      white_q <= white_d;
      open_q  <= open_d;
      tx_q    <= tx_d;
      to_q    <= to_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    txm_q <= '0;
    else if (send) txm_q <= fixed_mv;
  end

  assign eng_req     = (st_q == ST_PEND);
  assign eng_opening = open_q;
  assign tx_valid    = tx_q;
  assign tx_move     = txm_q;
  assign game_on     = (st_q != ST_IDLE);
  assign is_white    = white_q;
  assign timeout     = to_q;
  assign proto_err   = err_q;
endmodule

// File: rtl/gs_checker.sv
module gs_checker #(
  parameter int COL_W = 6,
  parameter int ROW_W = 6,
  localparam int MOVE_W = COL_W + ROW_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_valid,
  input logic [1:0]        line_kind,
  input logic              eng_req,
  input logic              eng_opening,
  input logic              eng_done,
  input logic              tx_valid,
  input logic [MOVE_W-1:0] tx_move,
  input logic              game_on,
  input logic              is_white,
  input logic              timeout,
  input logic              proto_err
);
  a_r2_white_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && line_kind == 2'd1) |=> (eng_req && eng_opening && is_white && game_on));

  a_r3_black_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && line_kind == 2'd2) |=> (game_on && !is_white && !eng_req && !tx_valid));

  a_r5_tx_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(eng_req && eng_done));

  a_r6_opening_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_opening && eng_done && !line_valid) |=>
      (tx_valid && tx_move[MOVE_W-1:2] == '0 && !tx_move[1]));

  a_r7_timeout_ends: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!game_on && !eng_req && !tx_valid && $past(eng_req && !eng_done)));

  a_r8_cmd_no_send: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && line_kind[1] != line_kind[0]) |=> !tx_valid);

  a_r9_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(line_valid && line_kind == 2'd3 && eng_req));

  a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_valid, timeout}));
endmodule

bind game_session_ctrl gs_checker #(.COL_W(COL_W), .ROW_W(ROW_W)) u_gs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_valid  (line_valid),
  .line_kind   (line_kind),
  .eng_req     (eng_req),
  .eng_opening (eng_opening),
  .eng_done    (eng_done),
  .tx_valid    (tx_valid),
  .tx_move     (tx_move),
  .game_on     (game_on),
  .is_white    (is_white),
  .timeout     (timeout),
  .proto_err   (proto_err)
);

// File: tb/game_session_ctrl_bench.sv
module game_session_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HZ    = 16;
  localparam int COL_W = 6;
  localparam int ROW_W = 6;
  localparam int MW    = COL_W + ROW_W + 2;

  typedef struct packed {
    logic [3:0]    tag;
    logic          lv;
    logic [1:0]    kind;
    logic          done;
    logic [MW-1:0] mv;
    logic          req;
    logic          opn;
    logic          tx;
    logic [MW-1:0] txm;
    logic          to;
    logic          err;
    logic          game;
    logic          wht;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    // tag lv kind done mv              req opn tx txm              to err game wht
    '{4'd2, 1'b1, 2'd1, 1'b0, 14'd0,             1'b1, 1'b1, 1'b0, 14'd0,             1'b0, 1'b0, 1'b1, 1'b1}, // R2
    '{4'd6, 1'b0, 2'd0, 1'b1, {6'd5, 6'd3, 2'd2},1'b0, 1'b0, 1'b1, {6'd0, 6'd0, 2'd1},1'b0, 1'b0, 1'b1, 1'b1}, // R6
    '{4'd5, 1'b0, 2'd0, 1'b0, 14'd0,             1'b0, 1'b0, 1'b0, 14'd0,             1'b0, 1'b0, 1'b1, 1'b1}, // R5
    '{4'd4, 1'b1, 2'd3, 1'b0, 14'd0,             1'b1, 1'b0, 1'b0, 14'd0,             1'b0, 1'b0, 1'b1, 1'b1}, // R4
    '{4'd4, 1'b0, 2'd0, 1'b0, 14'd0,             1'b1, 1'b0, 1'b0, 14'd0,             1'b0, 1'b0, 1'b1, 1'b1}, // R4
    '{4'd5, 1'b0, 2'd0, 1'b1, {6'd7, 6'd2, 2'd2},1'b0, 1'b0, 1'b1, {6'd7, 6'd2, 2'd2},1'b0, 1'b0, 1'b1, 1'b1}, // R5
    '{4'd10,1'b1, 2'd0, 1'b0, 14'd0,             1'b0, 1'b0, 1'b0, 14'd0,             1'b0, 1'b0, 1'b1, 1'b1}, // R10
    '{4'd3, 1'b1, 2'd2, 1'b0, 14'd0,             1'b0, 1'b0, 1'b0, 14'd0,             1'b0, 1'b0, 1'b1, 1'b0}, // R3
    '{4'd4, 1'b1, 2'd3, 1'b0, 14'd0,             1'b1, 1'b0, 1'b0, 14'd0,             1'b0, 1'b0, 1'b1, 1'b0}, // R4
    '{4'd9, 1'b1, 2'd3, 1'b0, 14'd0,             1'b1, 1'b0, 1'b0, 14'd0,             1'b0, 1'b1, 1'b1, 1'b0}, // R9
    '{4'd9, 1'b1, 2'd3, 1'b1, {6'd1, 6'd1, 2'd1},1'b0, 1'b0, 1'b1, {6'd1, 6'd1, 2'd1},1'b0, 1'b1, 1'b1, 1'b0}, // R9
    '{4'd5, 1'b0, 2'd0, 1'b1, {6'd9, 6'd9, 2'd0},1'b0, 1'b0, 1'b0, 14'd0,             1'b0, 1'b0, 1'b1, 1'b0}, // R5
    '{4'd2, 1'b1, 2'd1, 1'b0, 14'd0,             1'b1, 1'b1, 1'b0, 14'd0,             1'b0, 1'b0, 1'b1, 1'b1}, // R2
    '{4'd8, 1'b1, 2'd2, 1'b1, {6'd3, 6'd3, 2'd0},1'b0, 1'b0, 1'b0, 14'd0,             1'b0, 1'b0, 1'b1, 1'b0}, // R8
    '{4'd8, 1'b0, 2'd0, 1'b0, 14'd0,             1'b0, 1'b0, 1'b0, 14'd0,             1'b0, 1'b0, 1'b1, 1'b0}, // R8
    '{4'd2, 1'b1, 2'd1, 1'b0, 14'd0,             1'b1, 1'b1, 1'b0, 14'd0,             1'b0, 1'b0, 1'b1, 1'b1}, // R2
    '{4'd6, 1'b0, 2'd0, 1'b1, {6'd4, 6'd8, 2'd0},1'b0, 1'b0, 1'b1, {6'd0, 6'd0, 2'd0},1'b0, 1'b0, 1'b1, 1'b1}  // R6
  };

  logic          clk, rst_n, line_valid, eng_done;
  logic [1:0]    line_kind;
  logic [MW-1:0] eng_move, tx_move;
  logic          eng_req, eng_opening, tx_valid, game_on, is_white, timeout, proto_err;
  int            n_chk, n_err;
  bit            done_flag;

  game_session_ctrl #(.CLK_HZ(HZ), .COL_W(COL_W), .ROW_W(ROW_W)) u_game_session_ctrl (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_kind(line_kind),
    .eng_req(eng_req), .eng_opening(eng_opening), .eng_done(eng_done), .eng_move(eng_move),
    .tx_valid(tx_valid), .tx_move(tx_move), .game_on(game_on), .is_white(is_white),
    .timeout(timeout), .proto_err(proto_err));

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input int tag, input string what, input logic [MW-1:0] got, input logic [MW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic step(input logic lv, input logic [1:0] kind, input logic dn, input logic [MW-1:0] mv);
    @(negedge clk);
    line_valid = lv; line_kind = kind; eng_done = dn; eng_move = mv;
    @(posedge clk);
    #1;
    line_valid = 1'b0; eng_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    n_chk = 0; n_err = 0; done_flag = 1'b0;
    rst_n = 1'b0; line_valid = 1'b0; line_kind = 2'd0; eng_done = 1'b0; eng_move = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: values held during reset
    chk(1, "game_on in reset", MW'(game_on), '0);
    chk(1, "eng_req in reset", MW'(eng_req), '0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: values right after release
    chk(1, "tx_valid", MW'(tx_valid), '0);
    chk(1, "timeout", MW'(timeout), '0);
    chk(1, "proto_err", MW'(proto_err), '0);
    chk(1, "game_on", MW'(game_on), '0);

    // R10: move line with no game running
    step(1'b1, 2'd3, 1'b0, '0);
    chk(10, "req idle move", MW'(eng_req), '0);
    chk(10, "game idle move", MW'(game_on), '0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].lv, VEC[i].kind, VEC[i].done, VEC[i].mv);
      chk(VEC[i].tag, $sformatf("v%0d eng_req", i), MW'(eng_req), MW'(VEC[i].req));
      if (VEC[i].req) chk(VEC[i].tag, $sformatf("v%0d eng_opening", i), MW'(eng_opening), MW'(VEC[i].opn));
      chk(VEC[i].tag, $sformatf("v%0d tx_valid", i), MW'(tx_valid), MW'(VEC[i].tx));
      if (VEC[i].tx) chk(VEC[i].tag, $sformatf("v%0d tx_move", i), tx_move, VEC[i].txm);
      chk(VEC[i].tag, $sformatf("v%0d timeout", i), MW'(timeout), MW'(VEC[i].to));
      chk(VEC[i].tag, $sformatf("v%0d proto_err", i), MW'(proto_err), MW'(VEC[i].err));
      chk(VEC[i].tag, $sformatf("v%0d game_on", i), MW'(game_on), MW'(VEC[i].game));
      if (VEC[i].game) chk(VEC[i].tag, $sformatf("v%0d is_white", i), MW'(is_white), MW'(VEC[i].wht));
    end

    // R7: answer on the last allowed cycle is accepted
    step(1'b1, 2'd3, 1'b0, '0);
    for (int k = 0; k < HZ - 1; k++) step(1'b0, 2'd0, 1'b0, '0);
    chk(7, "req before deadline", MW'(eng_req), 1);
    step(1'b0, 2'd0, 1'b1, {6'd2, 6'd5, 2'd1});
    chk(7, "tx at deadline", MW'(tx_valid), 1);
    chk(7, "move at deadline", tx_move, {6'd2, 6'd5, 2'd1});
    chk(7, "no timeout", MW'(timeout), 0);

    // R7: no answer in time
    step(1'b1, 2'd3, 1'b0, '0);
    for (int k = 0; k < HZ - 1; k++) step(1'b0, 2'd0, 1'b0, '0);
    chk(7, "still pending", MW'(eng_req), 1);
    chk(7, "no early timeout", MW'(timeout), 0);
    step(1'b0, 2'd0, 1'b0, '0);
    chk(7, "timeout pulse", MW'(timeout), 1);
    chk(7, "game ended", MW'(game_on), 0);
    chk(7, "req dropped", MW'(eng_req), 0);
    chk(7, "no tx", MW'(tx_valid), 0);
    step(1'b0, 2'd0, 1'b0, '0);
    chk(7, "timeout one cycle", MW'(timeout), 0);

    // R10: move line after abandonment ignored
    step(1'b1, 2'd3, 1'b0, '0);
    chk(10, "req after abandon", MW'(eng_req), 0);
    chk(10, "err after abandon", MW'(proto_err), 0);

    finish_run();
  end
endmodule